// File: doc/BRIEF.md
# Performance Monitor Control Register File

This block holds the programmable control and status state of a small processor performance monitor and serves it over a coprocessor-style register port. Each request names one register through a primary field, a secondary field and an opcode. It also carries a read/write flag, 32-bit write data and the privilege of the requester, which is either user or kernel. One cycle later the block returns read data and a trap flag. The trap flag reports an access the requester may not make.

The block does no event counting itself. The counters it names are constant read-as-zero registers. Overflow status bits arrive through a separate inject port, so a test or a neighbouring counter can set them. Software clears them with write-one-to-clear writes.

A single kernel-owned user-enable bit controls whether user-level code may reach the monitor registers. This gate also covers the constant registers and the write-only increment register.

Top module: `pmc_regfile`

## Requirements
- R1: A register is mapped only when the primary field is 9 and one of these holds: secondary 12 with opcode 0 (control), 1 (enable-set), 2 (enable-clear), 3 (overflow status), 4 (software increment) or 5 (counter select); secondary 13 with opcode 0 (cycle count), 1 (event type) or 2 (event count); secondary 14 with opcode 0 (user enable). Any other selector traps.
- R2: When the requester is at user level and the user-enable bit is 0, every access except one to the user-enable register traps. This includes the constant and increment registers. A trapped access changes no state and returns read data 0.
- R3: The user-enable register holds only bit 0, and its other bits read 0. Kernel level may read and write it. User level may read it whatever its value. A user-level write to it traps.
- R4: A control register write changes only the bits set in 0x39. At reset the control register takes the ID input ANDed with 0xFF000000.
- R5: A write to enable-set ORs bit 31 of the write data into the shared enable register. A write to enable-clear clears bit 31 when bit 31 of the write data is 1. Both addresses read the same register, and its bits 30..0 read 0.
- R6: A write to overflow status clears every bit that is 1 in the write data. A cycle with the inject strobe high ORs the inject mask into overflow status.
- R7: An event type write stores write-data bits 7..0, and bits 31..8 read 0.
- R8: Cycle count, counter select and event count always read 0 and ignore writes. Software-increment writes have no effect, and a read of software increment traps.
- R9: The response strobe, read data and trap flag are registered. They appear in the cycle after the request strobe. A non-trapped write returns read data 0.
- R10: After reset, the enable, overflow, event type and user-enable registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqPrim | input | 4 | Primary register field |
| reqSec | input | 4 | Secondary register field |
| reqOpc | input | 3 | Opcode field |
| reqWdata | input | 32 | Write data |
| reqKernel | input | 1 | 1 = kernel level, 0 = user level |
| idValue | input | 32 | Identification word used for the control reset value |
| injValid | input | 1 | Overflow inject strobe |
| injMask | input | 32 | Overflow bits to set |
| rspValid | output | 1 | Response strobe, one cycle after request |
| rspRdata | output | 32 | Read data |
| rspTrap | output | 1 | Access not permitted |

## Verification
The assertions assume that request fields are stable and meaningful only in a cycle with the request strobe high. They also assume that a write-one-to-clear check is made only when no inject happens in the same cycle, because inject takes precedence in that cycle. The stimulus drives every request for a single cycle between idle cycles. It pulses inject only in cycles with no request. Random selectors cover the mapped space, near-miss opcodes and a wrong primary field. Privilege is also random, so the gate is exercised in both states.

// File: rtl/pmc_regfile_pkg.sv
package pmc_regfile_pkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_EN_SET, SEL_EN_CLR, SEL_OVF, SEL_SWINC,
    SEL_CNTSEL, SEL_CYC, SEL_EVTYPE, SEL_EVCNT, SEL_UEN
  } regSel_e;

  typedef struct packed {
    logic    respond;
    logic    trap;
    logic    rdEn;
    logic    wrCtrl;
    logic    wrEnSet;
    logic    wrEnClr;
    logic    wrOvf;
    logic    wrEvType;
    logic    wrUen;
    regSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/pmc_regctl.sv
module pmc_regctl
  import pmc_regfile_pkg::*;
#(
  parameter int PRIM_W   = 4,
  parameter int SEC_W    = 4,
  parameter int OPC_W    = 3,
  parameter int PRIM_MON = 9,
  parameter int SEC_A    = 12,
  parameter int SEC_B    = 13,
  parameter int SEC_U    = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [PRIM_W-1:0] reqPrim,
  input  logic [SEC_W-1:0]  reqSec,
  input  logic [OPC_W-1:0]  reqOpc,
  input  logic              reqKernel,
  input  logic              uenBit,
  output ctlStrobe_t        strobe
);

  regSel_e sel;
  logic    denied;
  logic    okAccess;

  always_comb begin
    sel = SEL_NONE;
    if (reqPrim == PRIM_W'(PRIM_MON)) begin
      if (reqSec == SEC_W'(SEC_A)) begin
        case (reqOpc)
          OPC_W'(0): sel = SEL_CTRL;
          OPC_W'(1): sel = SEL_EN_SET;
          OPC_W'(2): sel = SEL_EN_CLR;
          OPC_W'(3): sel = SEL_OVF;
          OPC_W'(4): sel = SEL_SWINC;
          OPC_W'(5): sel = SEL_CNTSEL;
          default:   sel = SEL_NONE;
        endcase
      end else if (reqSec == SEC_W'(SEC_B)) begin
        case (reqOpc)
          OPC_W'(0): sel = SEL_CYC;
          OPC_W'(1): sel = SEL_EVTYPE;
          OPC_W'(2): sel = SEL_EVCNT;
          default:   sel = SEL_NONE;
        endcase
      end else if (reqSec == SEC_W'(SEC_U) && reqOpc == '0) begin
        sel = SEL_UEN;
      end
    end
  end

  always_comb begin
    denied = 1'b0;
    if (sel == SEL_NONE) denied = 1'b1;
    else if (sel == SEL_UEN) denied = !reqKernel && reqWrite;
    else if (!reqKernel && !uenBit) denied = 1'b1;
    else if (sel == SEL_SWINC && !reqWrite) denied = 1'b1;
  end

  assign okAccess = reqValid && !denied;

  always_comb begin
    strobe          = '0;
    strobe.respond  = reqValid;
    strobe.trap     = reqValid && denied;
    strobe.rdEn     = okAccess && !reqWrite;
    strobe.rdSel    = sel;
    strobe.wrCtrl   = okAccess && reqWrite && sel == SEL_CTRL;
    strobe.wrEnSet  = okAccess && reqWrite && sel == SEL_EN_SET;
    strobe.wrEnClr  = okAccess && reqWrite && sel == SEL_EN_CLR;
    strobe.wrOvf    = okAccess && reqWrite && sel == SEL_OVF;
    strobe.wrEvType = okAccess && reqWrite && sel == SEL_EVTYPE;
    strobe.wrUen    = okAccess && reqWrite && sel == SEL_UEN;
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrCtrl, strobe.wrEnSet, strobe.wrEnClr, strobe.wrOvf,
              strobe.wrEvType, strobe.wrUen})); // R1
  AST_USER_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqKernel && !uenBit && reqSec != SEC_W'(SEC_U)) |-> strobe.trap); // R2
  AST_USER_UEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqKernel && reqWrite && reqPrim == PRIM_W'(PRIM_MON)
     && reqSec == SEC_W'(SEC_U)) |-> (strobe.trap && !strobe.wrUen)); // R3

endmodule

// File: rtl/pmc_regdata.sv
module pmc_regdata
  import pmc_regfile_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          EVT_W     = 8,
  parameter logic [31:0] CTRL_MASK = 32'h0000_0039,
  parameter logic [31:0] ID_MASK   = 32'hFF00_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] idValue,
  input  logic              injValid,
  input  logic [DATA_W-1:0] injMask,
  output logic              uenBit,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspTrap
);

  localparam int EN_BIT = DATA_W - 1;
  localparam logic [DATA_W-1:0] WMASK  = DATA_W'(CTRL_MASK);
  localparam logic [DATA_W-1:0] RMASK  = DATA_W'(ID_MASK);
  localparam logic [DATA_W-1:0] ENMASK = DATA_W'(1) << EN_BIT;

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] cntEn;
  logic [DATA_W-1:0] ovfReg;
  logic [EVT_W-1:0]  evtReg;
  logic              uenReg;
  logic [DATA_W-1:0] rdMux;
  logic [DATA_W-1:0] ovfClr;
  logic [DATA_W-1:0] ovfSet;

  assign uenBit = uenReg;
  assign ovfClr = strobe.wrOvf ? wdata : '0;
  assign ovfSet = injValid ? injMask : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= idValue & RMASK;
      cntEn   <= '0;
      ovfReg  <= '0;
      evtReg  <= '0;
      uenReg  <= 1'b0;
    end else begin
      if (strobe.wrCtrl)   ctrlReg <= (ctrlReg & ~WMASK) | (wdata & WMASK);
      if (strobe.wrEnSet)  cntEn   <= cntEn | (wdata & ENMASK);
      if (strobe.wrEnClr)  cntEn   <= cntEn & ~(wdata & ENMASK);
      if (strobe.wrEvType) evtReg  <= wdata[EVT_W-1:0];
      if (strobe.wrUen)    uenReg  <= wdata[0];
      ovfReg <= (ovfReg & ~ovfClr) | ovfSet;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_CTRL:              rdMux = ctrlReg;
      SEL_EN_SET, SEL_EN_CLR: rdMux = cntEn;
      SEL_OVF:               rdMux = ovfReg;
      SEL_EVTYPE:            rdMux = DATA_W'(evtReg);
      SEL_UEN:               rdMux = DATA_W'(uenReg);
      default:               rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspTrap  <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strobe.respond;
      rspTrap  <= strobe.trap;
      rspRdata <= strobe.rdEn ? rdMux : '0;
    end
  end

  AST_TRAP_NO_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trap |=> ($stable(ctrlReg) && $stable(cntEn) && $stable(evtReg)
                     && $stable(uenReg))); // R2
  AST_CTRL_MASK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCtrl |=> ((ctrlReg & ~WMASK) == $past(ctrlReg & ~WMASK))); // R4
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEnSet && wdata[EN_BIT]) |=> cntEn[EN_BIT]); // R5
  AST_OVF_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrOvf && !injValid) |=> ((ovfReg & $past(wdata)) == '0)); // R6
  AST_TRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rspTrap |-> (rspRdata == '0)); // R2
  AST_RESP_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    strobe.respond |=> rspValid); // R9

endmodule

// File: rtl/pmc_regfile.sv
module pmc_regfile
  import pmc_regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRIM_W = 4,
  parameter int SEC_W  = 4,
  parameter int OPC_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [PRIM_W-1:0] reqPrim,
  input  logic [SEC_W-1:0]  reqSec,
  input  logic [OPC_W-1:0]  reqOpc,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqKernel,
  input  logic [DATA_W-1:0] idValue,
  input  logic              injValid,
  input  logic [DATA_W-1:0] injMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspTrap
);

  ctlStrobe_t strobe;
  logic       uenBit;

  pmc_regctl #(.PRIM_W(PRIM_W), .SEC_W(SEC_W), .OPC_W(OPC_W)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPrim(reqPrim), .reqSec(reqSec), .reqOpc(reqOpc),
    .reqKernel(reqKernel), .uenBit(uenBit), .strobe(strobe)
  );

  pmc_regdata #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(reqWdata),
    .idValue(idValue), .injValid(injValid), .injMask(injMask),
    .uenBit(uenBit), .rspValid(rspValid), .rspRdata(rspRdata),
    .rspTrap(rspTrap)
  );

endmodule

// File: tb/pmc_regfile_tb.sv
`timescale 1ns/1ps
module pmc_regfile_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqKernel = 1'b0;
  logic [3:0]  reqPrim = '0, reqSec = '0;
  logic [2:0]  reqOpc = '0;
  logic [31:0] reqWdata = '0, injMask = '0;
  logic        injValid = 1'b0;
  logic [31:0] idValue = 32'hA5C3_1234;
  logic        rspValid, rspTrap;
  logic [31:0] rspRdata;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model
  logic [31:0] mCtrl, mEn, mOvf;
  logic [7:0]  mEvt;
  logic        mUen;

  always #2 clk = ~clk;

  pmc_regfile u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPrim(reqPrim), .reqSec(reqSec), .reqOpc(reqOpc), .reqWdata(reqWdata),
    .reqKernel(reqKernel), .idValue(idValue), .injValid(injValid),
    .injMask(injMask), .rspValid(rspValid), .rspRdata(rspRdata),
    .rspTrap(rspTrap)
  );

  function automatic bit isMapped(logic [3:0] p, logic [3:0] s, logic [2:0] o);
    return p == 4'd9 && ((s == 4'd12 && o <= 3'd5) || (s == 4'd13 && o <= 3'd2)
                         || (s == 4'd14 && o == 3'd0));
  endfunction

  function automatic bit expTrap(logic [3:0] p, logic [3:0] s, logic [2:0] o,
                                 bit wr, bit k, bit uen);
    if (!isMapped(p, s, o)) return 1;
    if (s == 4'd14) return !k && wr;
    if (!k && !uen) return 1;
    if (s == 4'd12 && o == 3'd4 && !wr) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] modelRead(logic [3:0] s, logic [2:0] o);
    if (s == 4'd12 && o == 3'd0) return mCtrl;
    if (s == 4'd12 && (o == 3'd1 || o == 3'd2)) return mEn;
    if (s == 4'd12 && o == 3'd3) return mOvf;
    if (s == 4'd13 && o == 3'd1) return {24'd0, mEvt};
    if (s == 4'd14) return {31'd0, mUen};
    return 32'd0;
  endfunction

  task automatic check(string tag, bit ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(string tag, logic [3:0] p, logic [3:0] s, logic [2:0] o,
                        bit wr, bit k, logic [31:0] wd);
    bit t;
    logic [31:0] er;
    t  = expTrap(p, s, o, wr, k, mUen);
    er = (t || wr) ? 32'd0 : modelRead(s, o);
    @(negedge clk);
    reqValid = 1; reqPrim = p; reqSec = s; reqOpc = o; reqWrite = wr;
    reqKernel = k; reqWdata = wd;
    @(negedge clk);
    reqValid = 0;
    check({tag, " valid"}, rspValid === 1'b1, {31'd0, rspValid}, 32'd1);
    check({tag, " trap"}, rspTrap === t, {31'd0, rspTrap}, {31'd0, t});
    check({tag, " rdata"}, rspRdata === er, rspRdata, er);
    if (!t && wr) begin
      if (s == 4'd12 && o == 3'd0) mCtrl = (mCtrl & ~32'h39) | (wd & 32'h39);
      if (s == 4'd12 && o == 3'd1) mEn = mEn | (wd & 32'h8000_0000);
      if (s == 4'd12 && o == 3'd2) mEn = mEn & ~(wd & 32'h8000_0000);
      if (s == 4'd12 && o == 3'd3) mOvf = mOvf & ~wd;
      if (s == 4'd13 && o == 3'd1) mEvt = wd[7:0];
      if (s == 4'd14) mUen = wd[0];
    end
  endtask

  task automatic inject(logic [31:0] m);
    @(negedge clk);
    injValid = 1; injMask = m;
    @(negedge clk);
    injValid = 0;
    mOvf = mOvf | m;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mCtrl = 32'hA500_0000; mEn = 0; mOvf = 0; mEvt = 0; mUen = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R9 idle after reset", rspValid === 1'b0, {31'd0, rspValid}, 32'd0);
    // reset values (R4, R10)
    access("R4 ctrl reset", 9, 12, 0, 0, 1, 0);
    access("R10 enable reset", 9, 12, 1, 0, 1, 0);
    access("R10 ovf reset", 9, 12, 3, 0, 1, 0);
    access("R10 evtype reset", 9, 13, 1, 0, 1, 0);
    access("R10 uen reset", 9, 14, 0, 0, 1, 0);
    // user gate closed (R2)
    access("R2 user ctrl write", 9, 12, 0, 1, 0, 32'hFFFF_FFFF);
    access("R2 user cycle read", 9, 13, 0, 0, 0, 0);
    access("R2 user swinc write", 9, 12, 4, 1, 0, 1);
    access("R2 ctrl unchanged", 9, 12, 0, 0, 1, 0);
    access("R3 user uen read", 9, 14, 0, 0, 0, 0);
    access("R3 user uen write", 9, 14, 0, 1, 0, 1);
    access("R3 uen still zero", 9, 14, 0, 0, 1, 0);
    // mask and aliasing (R4, R5, R7)
    access("R4 ctrl write", 9, 12, 0, 1, 1, 32'hFFFF_FFFF);
    access("R4 ctrl masked", 9, 12, 0, 0, 1, 0);
    access("R5 set", 9, 12, 1, 1, 1, 32'hFFFF_FFFF);
    access("R5 read via clr", 9, 12, 2, 0, 1, 0);
    access("R5 clr", 9, 12, 2, 1, 1, 32'h8000_0000);
    access("R5 read via set", 9, 12, 1, 0, 1, 0);
    access("R7 evtype write", 9, 13, 1, 1, 1, 32'hDEAD_BEEF);
    access("R7 evtype read", 9, 13, 1, 0, 1, 0);
    // overflow (R6)
    inject(32'hF0F0_00FF);
    access("R6 ovf after inject", 9, 12, 3, 0, 1, 0);
    access("R6 ovf w1c", 9, 12, 3, 1, 1, 32'h3000_000F);
    access("R6 ovf after clear", 9, 12, 3, 0, 1, 0);
    // constant and swinc (R8), unmapped (R1)
    access("R8 cycle write", 9, 13, 0, 1, 1, 32'h1234_5678);
    access("R8 cycle read", 9, 13, 0, 0, 1, 0);
    access("R8 cntsel read", 9, 12, 5, 0, 1, 0);
    access("R8 evcnt read", 9, 13, 2, 0, 1, 0);
    access("R8 swinc read", 9, 12, 4, 0, 1, 0);
    access("R1 bad opcode", 9, 12, 6, 0, 1, 0);
    access("R1 bad primary", 8, 12, 0, 0, 1, 0);
    access("R1 bad uen opc", 9, 14, 1, 0, 1, 0);
    // open the gate (R3) then user access works
    access("R3 kernel uen write", 9, 14, 0, 1, 1, 32'hFFFF_FFFF);
    access("R3 uen bit0 only", 9, 14, 0, 0, 1, 0);
    access("R2 user read open", 9, 12, 0, 0, 0, 0);
    access("R9 write rdata zero", 9, 13, 1, 1, 0, 32'h55);
    // random mix
    void'($urandom(32'h5EED));
    for (int i = 0; i < 400; i++) begin
      logic [3:0] p, s;
      logic [2:0] o;
      logic [31:0] r;
      r = $urandom;
      p = (r[3:0] == 0) ? 4'd8 : 4'd9;
      s = 4'd12 + 4'(r[5:4] % 3);
      o = r[8:6];
      if (r[15:12] == 0) inject($urandom);
      access("R1 R2 random", p, s, o, r[9], r[10], $urandom);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule